// File: doc/BRIEF.md
# AES3 Biphase-Mark Audio Transmitter

This block turns a stream of parallel audio words into a single AES3-style serial line. It runs on one clock whose period is one half-slot, so each subframe of 32 time slots takes 64 clock cycles. A frame is two subframes: channel A first, then channel B. Every 192 frames form a channel-status block. The block reads one sample from a show-ahead FIFO per subframe. It computes the parity bit and chooses the correct preamble. It then drives the line with biphase-mark coding, so a receiver can recover both the clock and the data from the one wire.

The channel-status block comes from a 184-bit parallel input. The block copies this input at the start of each 192-frame block. It sends one status bit per frame, and it sends the same bit in both subframes of that frame. The last eight frames of the block carry a CRC byte that the block computes in hardware as the status bits go out. If the FIFO is empty when a sample is due, the block sends a null sample in its place and the line carries on without a gap.

Top module: `aes3_tx`

## Requirements
- R1: While `rst_n` is low, `sdo` and `fifo_rd` are low, even if the FIFO holds data. The first subframe starts on the first rising edge after `rst_n` goes high. Each subframe then lasts exactly 64 clock cycles, one cycle per half-slot.
- R2: The slots of a subframe are laid out as follows:
  - Slots 4 to 7 carry `fifo_data[3:0]`.
  - Slots 8 to 27 carry the 20-bit audio word `fifo_data[23:4]`, least significant bit first. In general, slot 4+i carries `fifo_data[i]`.
  - Slot 28 carries `fifo_v`, slot 29 carries `fifo_u`, slot 30 carries the channel-status bit and slot 31 carries the parity bit.
- R3: Each of slots 4 to 31 is biphase-mark coded. The line changes level at the start of every slot, and changes again at mid-slot only when the bit is 1.
- R4: Slots 0 to 3 hold a preamble of eight half-slots, listed here first half first, for a preceding line level of low:
  - Z = 11101000 on channel A of frame 0 of each block.
  - X = 11100010 on every other channel A.
  - Y = 11100100 on every channel B.
  - When the preceding line level is high, the pattern is inverted.
- R5: The parity slot makes slots 4 to 31 hold an even number of ones. As a result, the line is low in the last half-slot of every subframe.
- R6: `fifo_rd` goes high for one cycle, only in the last half-slot cycle of a subframe, and only when `fifo_empty` is low. The word shown in that cycle is sent in the next subframe. Successive reads therefore alternate between channels A and B.
- R7: If `fifo_empty` is high in the last half-slot cycle, the block does not read. The next subframe then carries zero in slots 4 to 27, with V = 1 and U = 0.
- R8: For frame f below 184 in a block, both subframes carry channel-status bit `cs_block[f]`. The block copies `cs_block` when it loads channel A of frame 0. A change to `cs_block` during a block therefore takes effect only at the next block.
- R9: The CRC register works as follows:
  - It is preset to 8'hFF.
  - It takes in status bits 0 to 183 in the order they are sent.
  - On each bit, it shifts left with feedback from its most significant bit XOR the new bit. The feedback mask is 8'h1D, which is x^8+x^4+x^3+x^2+1.
  - Frames 184 to 191 then carry register bits 0 to 7 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-slot clock (twice the slot rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty | input | 1 | FIFO holds no sample |
| fifo_data | input | 24 | Head sample: [3:0] auxiliary, [23:4] audio |
| fifo_v | input | 1 | Validity bit of the head sample |
| fifo_u | input | 1 | User bit of the head sample |
| fifo_rd | output | 1 | Consumes the head sample |
| cs_block | input | 184 | Channel-status bits 0 to 183 |
| sdo | output | 1 | Biphase-mark serial line |

## Verification
Some properties are checked on every cycle:
- a level change at every slot boundary of the data region;
- a mid-slot change exactly where the stored subframe word holds a 1;
- a transition at the first half of every preamble;
- a low line at the end of each subframe;
- single-cycle reads only at the subframe boundary;
- null contents after an empty boundary.

Other behaviour can only be shown by the bench scenarios, which decode whole subframes:
- correct X/Y/Z choice across two 192-frame blocks;
- the content and order of samples through FIFO drain and refill;
- the CRC byte;
- the rule that a `cs_block` change in the middle of a block takes effect only at the next block.

// File: rtl/aes3_tx_pkg.sv
package aes3_tx_pkg;
  localparam int SAMPLE_W   = 24;   // auxiliary + audio field
  localparam int SLOT_N     = 32;
  localparam int PRE_SLOTS  = 4;
  localparam int PRE_HALF   = 2 * PRE_SLOTS;
  localparam int HALF_N     = 2 * SLOT_N;
  localparam int FRAME_N    = 192;
  localparam int CS_DATA_N  = 184;
  localparam int CRC_W      = 8;
  localparam logic [CRC_W-1:0] CRC_MASK = 8'h1D;
  localparam logic [CRC_W-1:0] CRC_SEED = 8'hFF;

  typedef enum logic [1:0] {PRE_X, PRE_Y, PRE_Z} pre_e;

  // Preamble half-slot pattern, MSB sent first, for the given prior level.
  function automatic logic [PRE_HALF-1:0] pre_pattern(pre_e kind, logic prior);
    logic [PRE_HALF-1:0] p;
    case (kind)
      PRE_Z:   p = 8'b1110_1000;
      PRE_Y:   p = 8'b1110_0100;
      default: p = 8'b1110_0010;
    endcase
    return prior ? ~p : p;
  endfunction

  // One serial step of the status-block CRC.
  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] r, logic b);
    logic fb;
    fb = r[CRC_W-1] ^ b;
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_MASK : '0);
  endfunction

  // Even parity bit over the payload slots.
  function automatic logic even_fill(logic [SLOT_N-PRE_SLOTS-2:0] payload);
    return ^payload;
  endfunction
endpackage

// File: rtl/aes3_tx_seq.sv
module aes3_tx_seq
  import aes3_tx_pkg::*;
#(
  parameter int HN = HALF_N,
  parameter int FN = FRAME_N,
  localparam int HS_W = $clog2(HN),
  localparam int FR_W = $clog2(FN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_empty,
  output logic            fifo_rd,
  output logic            load,
  output logic [HS_W-1:0] hs,
  output logic            nxt_sub,
  output logic [FR_W-1:0] nxt_frame,
  output logic            block_start,
  output pre_e            nxt_pre
);
  logic [HS_W-1:0] hs_q;
  logic            sub_q;
  logic [FR_W-1:0] frame_q;

  assign hs          = hs_q;
  assign load        = (hs_q == HS_W'(HN - 1));
  assign nxt_sub     = ~sub_q;
  assign nxt_frame   = !sub_q ? frame_q :
                       (frame_q == FR_W'(FN - 1)) ? '0 : frame_q + 1'b1;
  assign block_start = load && !nxt_sub && (nxt_frame == '0);
  assign nxt_pre     = nxt_sub ? PRE_Y : ((nxt_frame == '0) ? PRE_Z : PRE_X);
  assign fifo_rd     = load && !fifo_empty && rst_n;

  // Reset parks the sequencer on the last half-slot of channel B, last frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= HS_W'(HN - 1);
      sub_q   <= 1'b1;
      frame_q <= FR_W'(FN - 1);
    end else begin
      hs_q <= hs_q + 1'b1;
      if (load) begin
        sub_q   <= nxt_sub;
        frame_q <= nxt_frame;
      end
    end
  end
endmodule

// File: rtl/aes3_tx_cs.sv
module aes3_tx_cs
  import aes3_tx_pkg::*;
#(
  parameter int FN = FRAME_N,
  parameter int CSN = CS_DATA_N,
  parameter int CW = CRC_W,
  localparam int FR_W = $clog2(FN),
  localparam int CI_W = $clog2(CW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            nxt_sub,
  input  logic [FR_W-1:0] nxt_frame,
  input  logic            block_start,
  input  logic [CSN-1:0]  cs_block,
  output logic            cs_bit
);
  logic [CSN-1:0]  cs_sh;
  logic [CW-1:0]   crc_q;
  logic            c_hold;
  logic [FR_W-1:0] crc_off;
  logic            in_data;

  assign crc_off = nxt_frame - FR_W'(CSN);
  assign in_data = (nxt_frame < FR_W'(CSN));

  always_comb begin
    if (nxt_sub)          cs_bit = c_hold;
    else if (block_start) cs_bit = cs_block[0];
    else if (in_data)     cs_bit = cs_sh[0];
    else                  cs_bit = crc_q[crc_off[CI_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh  <= '0;
      crc_q  <= CRC_SEED;
      c_hold <= 1'b0;
    end else if (load && !nxt_sub) begin
      c_hold <= cs_bit;
      if (block_start) begin
        cs_sh <= cs_block >> 1;
        crc_q <= crc_step(CRC_SEED, cs_block[0]);
      end else if (in_data) begin
        cs_sh <= cs_sh >> 1;
        crc_q <= crc_step(crc_q, cs_sh[0]);
      end
    end
  end
endmodule

// File: rtl/aes3_tx_bmc.sv
module aes3_tx_bmc
  import aes3_tx_pkg::*;
#(
  parameter int SN = SLOT_N,
  localparam int HN = 2 * SN,
  localparam int HS_W = $clog2(HN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [HS_W-1:0] hs,
  input  logic [SN-1:0]   word_in,
  input  pre_e            pre_kind,
  output logic [SN-1:0]   word_q,
  output logic            sdo
);
  logic                lvl, lvl_n;
  logic [PRE_HALF-1:0] pat_q, pat_n;
  logic [HS_W-1:0]     nhs;

  assign nhs   = hs + 1'b1;
  assign pat_n = pre_pattern(pre_kind, lvl);
  assign sdo   = lvl;

  always_comb begin
    if (load)                         lvl_n = pat_n[PRE_HALF-1];
    else if (nhs < HS_W'(PRE_HALF))   lvl_n = pat_q[~nhs[2:0]];
    else if (!nhs[0])                 lvl_n = ~lvl;
    else                              lvl_n = lvl ^ word_q[nhs[HS_W-1:1]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl    <= 1'b0;
      pat_q  <= '0;
      word_q <= '0;
    end else begin
      lvl <= lvl_n;
      if (load) begin
        pat_q  <= pat_n;
        word_q <= word_in;
      end
    end
  end
endmodule

// File: rtl/aes3_tx.sv
module aes3_tx
  import aes3_tx_pkg::*;
#(
  parameter int SW  = SAMPLE_W,
  parameter int SN  = SLOT_N,
  parameter int FN  = FRAME_N,
  parameter int CSN = CS_DATA_N,
  localparam int HN   = 2 * SN,
  localparam int HS_W = $clog2(HN),
  localparam int FR_W = $clog2(FN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fifo_empty,
  input  logic [SW-1:0]  fifo_data,
  input  logic           fifo_v,
  input  logic           fifo_u,
  output logic           fifo_rd,
  input  logic [CSN-1:0] cs_block,
  output logic           sdo
);
  logic            load, nxt_sub, block_start, cs_bit;
  logic [HS_W-1:0] hs;
  logic [FR_W-1:0] nxt_frame;
  pre_e            nxt_pre;
  logic [SN-1:0]   word_in, word_q;
  logic [SW-1:0]   smp;
  logic            v_bit, u_bit, par;

  aes3_tx_seq #(.HN(HN), .FN(FN)) u_seq (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
    .load(load), .hs(hs), .nxt_sub(nxt_sub), .nxt_frame(nxt_frame),
    .block_start(block_start), .nxt_pre(nxt_pre));

  aes3_tx_cs #(.FN(FN), .CSN(CSN), .CW(CRC_W)) u_cs (
    .clk(clk), .rst_n(rst_n), .load(load), .nxt_sub(nxt_sub),
    .nxt_frame(nxt_frame), .block_start(block_start), .cs_block(cs_block),
    .cs_bit(cs_bit));

  // Null fill when nothing is waiting at the boundary.
  assign smp   = fifo_empty ? '0   : fifo_data;
  assign v_bit = fifo_empty ? 1'b1 : fifo_v;
  assign u_bit = fifo_empty ? 1'b0 : fifo_u;
  assign par   = even_fill({cs_bit, u_bit, v_bit, smp});
  assign word_in = {par, cs_bit, u_bit, v_bit, smp, {PRE_SLOTS{1'b0}}};

  aes3_tx_bmc #(.SN(SN)) u_bmc (
    .clk(clk), .rst_n(rst_n), .load(load), .hs(hs), .word_in(word_in),
    .pre_kind(nxt_pre), .word_q(word_q), .sdo(sdo));
endmodule

// File: rtl/aes3_tx_chk.sv
module aes3_tx_chk
  import aes3_tx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sdo,
  input logic              fifo_rd,
  input logic              fifo_empty,
  input logic              load,
  input logic [5:0]        hs,
  input logic [SLOT_N-1:0] word_q
);
  // R3: every data slot opens with a level change
  a_r3_slot_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (hs >= 6'(PRE_HALF) && !hs[0]) |-> (sdo != $past(sdo)));
  // R2, R3: mid-slot change exactly when the stored slot bit is one
  a_r2_mid_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (hs >= 6'(PRE_HALF) && hs[0]) |-> ((sdo != $past(sdo)) == word_q[hs[5:1]]));
  // R4: every preamble starts with a transition
  a_r4_pre_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (hs == 6'd0) |-> (sdo != $past(sdo)));
  // R5: line is low in the last half-slot
  a_r5_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    (hs == 6'(HALF_N - 1)) |-> !sdo);
  // R6: reads are single cycles at the boundary only
  a_r6_read_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (load && !fifo_empty));
  a_r6_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> !fifo_rd);
  // R7: empty boundary loads a null sample
  a_r7_null_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (load && fifo_empty) |=> (word_q[27:4] == '0 && word_q[28] && !word_q[29]));
endmodule

bind aes3_tx aes3_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .fifo_rd(fifo_rd),
  .fifo_empty(fifo_empty), .load(load), .hs(hs), .word_q(word_q));

// File: tb/sim_aes3_tx.sv
module sim_aes3_tx;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fifo_empty = 1'b1;
  logic [23:0]  fifo_data = '0;
  logic         fifo_v = 1'b0;
  logic         fifo_u = 1'b0;
  logic [183:0] cs_block = '0;
  wire          fifo_rd;
  wire          sdo;

  localparam int SUBS = 772;

  aes3_tx u0 (.clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_v(fifo_v), .fifo_u(fifo_u),
    .fifo_rd(fifo_rd), .cs_block(cs_block), .sdo(sdo));

  always #5 clk = ~clk;

  typedef struct packed { logic [23:0] d; logic v; logic u; } item_t;
  item_t fifo_q[$];
  item_t exp_q[$];
  logic [183:0] blk_cs [0:3];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(logic [183:0] blk);
    logic [7:0] r = 8'hFF;
    for (int i = 0; i < 184; i++) begin
      logic top = r[7];
      r = r << 1;
      if (top != blk[i]) r = r ^ 8'h1D;
    end
    return r;
  endfunction

  // Expected half-slot levels, index = half-slot number.
  function automatic logic [63:0] ref_wave(logic [7:0] pre, logic [27:0] body);
    logic [63:0] w;
    logic cur;
    for (int j = 0; j < 8; j++) w[j] = pre[7-j];
    cur = w[7];
    for (int s = 4; s < 32; s++) begin
      cur = ~cur;            w[2*s] = cur;
      if (body[s-4]) cur = ~cur;
      w[2*s+1] = cur;
    end
    return w;
  endfunction

  task automatic show_head();
    if (fifo_q.size() > 0) begin
      fifo_empty = 1'b0; fifo_data = fifo_q[0].d;
      fifo_v = fifo_q[0].v; fifo_u = fifo_q[0].u;
    end else begin
      fifo_empty = 1'b1; fifo_data = $urandom; fifo_v = 1'b0; fifo_u = 1'b1;
    end
  endtask

  task automatic add_items(int n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.d = $urandom; it.v = 1'($urandom); it.u = 1'($urandom);
      fifo_q.push_back(it);
    end
  endtask

  task automatic judge(int k, logic [63:0] lv);
    item_t e = exp_q.pop_front();
    int f = (k / 2) % 192;
    logic [183:0] blk = blk_cs[k / 384];
    logic [7:0] crc = ref_crc(blk);
    logic c_exp = (f < 184) ? blk[f] : crc[f - 184];
    logic [7:0] pre_exp, pre_got;
    logic [27:0] body, got;
    bit is_null = (e.v && !e.u && e.d == '0);
    pre_exp = (k % 2) ? 8'b11100100 : (f == 0 ? 8'b11101000 : 8'b11100010);
    for (int j = 0; j < 8; j++) pre_got[7-j] = lv[j];
    for (int s = 4; s < 32; s++) got[s-4] = lv[2*s] ^ lv[2*s+1];
    body[23:0] = e.d; body[24] = e.v; body[25] = e.u; body[26] = c_exp;
    body[27] = ^body[26:0];
    check("R4", $sformatf("preamble sub %0d", k), 64'(pre_got), 64'(pre_exp));
    check(is_null ? "R7" : "R2", $sformatf("sample sub %0d", k), 64'(got[23:0]), 64'(e.d));
    check(is_null ? "R7" : "R2", $sformatf("V/U sub %0d", k), 64'(got[25:24]), 64'({e.u, e.v}));
    check(f < 184 ? "R8" : "R9", $sformatf("status bit frame %0d sub %0d", f, k), 64'(got[26]), 64'(c_exp));
    check("R5", $sformatf("parity/end level sub %0d", k), 64'({^got, lv[63]}), 64'(0));
    check("R3", $sformatf("waveform sub %0d", k), lv, ref_wave(pre_exp, body));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [183:0] cs_a, cs_b;
    logic [63:0] lv;
    int idx, sub_k;
    bit pop_pend;
    item_t nul;
    nul.d = '0; nul.v = 1'b1; nul.u = 1'b0;
    for (int i = 0; i < 184; i++) begin
      cs_a[i] = 1'($urandom); cs_b[i] = 1'($urandom);
    end
    cs_block = cs_a;
    fifo_q.push_back('{24'hFFFFFF, 1'b0, 1'b1});
    fifo_q.push_back('{24'h000000, 1'b1, 1'b1});
    fifo_q.push_back('{24'hAAAAAA, 1'b0, 1'b0});
    fifo_q.push_back('{24'h800001, 1'b1, 1'b0});
    add_items(37);
    show_head();
    repeat (3) begin
      @(negedge clk); #1;
      check("R1", "sdo in reset", 64'(sdo), 64'(0));
      check("R1", "fifo_rd in reset", 64'(fifo_rd), 64'(0));
    end
    @(negedge clk);
    rst_n = 1'b1;
    idx = 63; sub_k = -1; pop_pend = 0; lv = '0;
    while (sub_k < SUBS) begin
      if (pop_pend) begin void'(fifo_q.pop_front()); pop_pend = 0; end
      if (idx == 0 && sub_k == 100) cs_block = cs_b;
      if (idx == 0 && sub_k == 150) add_items(31);
      if (idx == 0 && sub_k == 500) add_items(120);
      show_head();
      #1;
      lv[idx] = sdo;
      if (idx == 63) begin
        if (sub_k >= 0) judge(sub_k, lv);
        if (sub_k + 1 < SUBS) begin
          check("R6", $sformatf("read at boundary before sub %0d", sub_k + 1),
                64'(fifo_rd), 64'(!fifo_empty));
          if ((sub_k + 1) % 384 == 0) blk_cs[(sub_k + 1) / 384] = cs_block;
          exp_q.push_back(fifo_rd ? fifo_q[0] : nul);
          if (fifo_rd) pop_pend = 1;
        end
        sub_k++; idx = 0;
      end else begin
        if (idx == 20)
          check("R6", $sformatf("no read mid sub %0d", sub_k), 64'(fifo_rd), 64'(0));
        idx++;
      end
      @(negedge clk);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule